// File: doc/BRIEF.md
# Shared-Memory Circular Queue Pointer Manager

This block keeps the read and write pointers of a set of circular queues that all live in one external word-addressed memory. The memory has a 24-bit address that reaches 16M words of 16 bits. Each queue owns a region whose bounds are set at a granularity of 16K words: a 10-bit first-region number and a 10-bit last-region number supply the top ten address bits. A producer and a consumer each present a queue index and a one-word request per cycle. The block answers at once, in the same cycle, with the memory word address to use and whether the request is taken. On the following clock edge it advances the pointer, wrapping at the end of the region, and updates the queue's fill count.

The low-numbered queues form a receive class. Each of these has a fill threshold, and its watermark flag asks for flow control or an interrupt. The remaining queues have no threshold. Every queue keeps a sticky overflow bit that records a dropped write. Writing a queue's first-region value re-arms that queue, and a global flush re-arms all queues at once. Software must re-arm a queue after configuring it and again after its port is disconnected. The block never checks whether regions overlap.

Top module: `qpm_core`

## Requirements
- R1: After reset every queue covers region 0 only (addresses 0x000000 to 0x003FFF), both pointers are 0, its fill is 0, and no watermark or overflow bit is set.
- R2: `wr_addr` always shows the write pointer of queue `wr_qid`, and `rd_addr` always shows the read pointer of queue `rd_qid`. Both are combinational in the same cycle.
- R3: An accepted access moves its pointer by one word on the next edge. A pointer that stands on `{last,14'h3FFF}` moves to `{first,14'h0000}` instead.
- R4: The capacity of a queue is (last − first + 1) × 16384 words when last ≥ first, and 0 otherwise. `wr_accept` is `wr_req` and (fill < capacity). An accepted write adds one to the fill.
- R5: A write request that is not accepted sets bit q of `ovf_status`. The bit stays set until `ovf_clr` bit q is 1 (write-one-to-clear). A set in the same cycle wins over the clear.
- R6: `rd_valid` is `rd_req` and (fill > 0). A refused read leaves the read pointer and the fill unchanged.
- R7: Accept decisions use the fill held before the edge. A write and a read to the same queue that are both accepted leave the fill unchanged.
- R8: A configuration write with `cfg_field` = 2'b00 sets the first region of queue `cfg_qid`. It also moves both of that queue's pointers to the new region start and zeroes the fill, overriding that queue's traffic in the same cycle. The overflow bit is kept.
- R9: `cfg_field` = 2'b01 sets the last region and leaves the pointers alone. `cfg_field` = 2'b10 sets the threshold, and only for queues below `NUM_WMQ`. Code 2'b11 does nothing.
- R10: A one-cycle `flush_all` moves every queue's pointers to its region start and zeroes every fill. Configuration and overflow bits are kept.
- R11: For a queue below `NUM_WMQ`, `watermark` bit q is high when the threshold is nonzero and fill ≥ threshold × 16384. For all other queues it is always low.
- R12: Queues with overlapping regions are accepted and keep fully independent pointers and fills.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_qid | input | QID_W | Queue index of the configuration write |
| cfg_field | input | 2 | 00 first region, 01 last region, 10 threshold, 11 none |
| cfg_data | input | REG_W | 10-bit region number or threshold |
| flush_all | input | 1 | Re-arm all queues |
| ovf_clr | input | NUM_Q | Write-one-to-clear for overflow bits |
| wr_req | input | 1 | Write request |
| wr_qid | input | QID_W | Write queue index |
| wr_addr | output | ADDR_W | Memory address for the write |
| wr_accept | output | 1 | Write is taken |
| rd_req | input | 1 | Read request |
| rd_qid | input | QID_W | Read queue index |
| rd_addr | output | ADDR_W | Memory address for the read |
| rd_valid | output | 1 | Read is taken (queue not empty) |
| watermark | output | NUM_Q | Per-queue threshold flag |
| ovf_status | output | NUM_Q | Per-queue sticky overflow |

## Verification
The pointer logic is tried with several input patterns. A long single-queue fill of exactly one region plus extra writes separates a correct capacity limit from an off-by-one, and shows the watermark edge and the overflow bit. A full drain followed by further writes shows whether the pointers wrap to the region start. Random traffic, with reads and writes often hitting the same queue in one cycle, tells whether fill updates use the fill from before the edge. Directed cycles place a re-arm, a last-region change, a flush or an overflow clear in the same cycle as traffic, which exposes the wrong priority among them. An overlapping pair of queues and an inverted region show that queues stay apart and that a region of zero capacity refuses all writes.

// File: rtl/qpm_pkg.sv
package qpm_pkg;
    localparam int unsigned ADDR_W = 24;
    localparam int unsigned REG_W  = 10;
    localparam int unsigned OFS_W  = ADDR_W - REG_W;
    localparam int unsigned OCC_W  = ADDR_W + 1;

    typedef enum logic [1:0] {
        FLD_FIRST  = 2'b00,
        FLD_LAST   = 2'b01,
        FLD_THRESH = 2'b10,
        FLD_NONE   = 2'b11
    } cfg_field_e;

    typedef struct packed {
        logic [REG_W-1:0]  first_reg;
        logic [REG_W-1:0]  last_reg;
        logic [REG_W-1:0]  thr_reg;
        logic [ADDR_W-1:0] wptr;
        logic [ADDR_W-1:0] rptr;
        logic [OCC_W-1:0]  fill;
        logic              ovf;
    } slot_state_t;
endpackage

// File: rtl/qpm_bound_calc.sv
module qpm_bound_calc
    import qpm_pkg::*;
(
    input  logic [REG_W-1:0]  first_i,
    input  logic [REG_W-1:0]  last_i,
    output logic [ADDR_W-1:0] base_o,
    output logic [ADDR_W-1:0] top_o,
    output logic [OCC_W-1:0]  cap_o
);
    logic [OCC_W-1:0] regions;

    always_comb begin
        base_o  = {first_i, {OFS_W{1'b0}}};
        top_o   = {last_i, {OFS_W{1'b1}}};
        regions = OCC_W'(last_i) - OCC_W'(first_i) + OCC_W'(1);
        if (last_i >= first_i) begin
            cap_o = regions << OFS_W;
        end else begin
            cap_o = '0;
        end
    end
endmodule

// File: rtl/qpm_watermark.sv
module qpm_watermark
    import qpm_pkg::*;
#(
    parameter bit HAS_WM = 1'b1
) (
    input  logic [OCC_W-1:0] fill_i,
    input  logic [REG_W-1:0] thr_i,
    output logic             flag_o
);
    logic [OCC_W-1:0] level;
    logic             hit;

    always_comb begin
        level  = OCC_W'(thr_i) << OFS_W;
        hit    = (thr_i != '0) && (fill_i >= level);
        flag_o = HAS_WM ? hit : 1'b0;
    end
endmodule

// File: rtl/qpm_queue_slot.sv
module qpm_queue_slot
    import qpm_pkg::*;
#(
    parameter bit HAS_WM = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              first_we_i,
    input  logic              last_we_i,
    input  logic              thr_we_i,
    input  logic [REG_W-1:0]  cfg_data_i,
    input  logic              flush_i,
    input  logic              wr_hit_i,
    input  logic              rd_hit_i,
    input  logic              ovf_clr_i,
    output logic [ADDR_W-1:0] wptr_o,
    output logic [ADDR_W-1:0] rptr_o,
    output logic              full_o,
    output logic              empty_o,
    output logic              wmark_o,
    output logic              ovf_o
);
    slot_state_t s_d, s_q;

    logic [ADDR_W-1:0] base, top;
    logic [OCC_W-1:0]  cap;
    logic              wr_go, rd_go;

    qpm_bound_calc u_bound (
        .first_i (s_q.first_reg),
        .last_i  (s_q.last_reg),
        .base_o  (base),
        .top_o   (top),
        .cap_o   (cap)
    );

    qpm_watermark #(.HAS_WM(HAS_WM)) u_wm (
        .fill_i (s_q.fill),
        .thr_i  (s_q.thr_reg),
        .flag_o (wmark_o)
    );

    function automatic logic [ADDR_W-1:0] step_ptr(
        input logic [ADDR_W-1:0] p,
        input logic [ADDR_W-1:0] lo,
        input logic [ADDR_W-1:0] hi
    );
        return (p == hi) ? lo : p + ADDR_W'(1);
    endfunction

    always_comb begin
        full_o  = (s_q.fill >= cap);
        empty_o = (s_q.fill == '0);
        wr_go   = wr_hit_i && !full_o;
        rd_go   = rd_hit_i && !empty_o;

        s_d = s_q;
        if (wr_go) s_d.wptr = step_ptr(s_q.wptr, base, top);
        if (rd_go) s_d.rptr = step_ptr(s_q.rptr, base, top);
        case ({wr_go, rd_go})
            2'b10:   s_d.fill = s_q.fill + OCC_W'(1);
            2'b01:   s_d.fill = s_q.fill - OCC_W'(1);
            default: s_d.fill = s_q.fill;
        endcase

        if (ovf_clr_i) s_d.ovf = 1'b0;
        if (wr_hit_i && !wr_go) s_d.ovf = 1'b1;

        if (last_we_i) s_d.last_reg = cfg_data_i;
        if (thr_we_i && HAS_WM) s_d.thr_reg = cfg_data_i;
        if (first_we_i) begin
            s_d.first_reg = cfg_data_i;
            s_d.wptr      = {cfg_data_i, {OFS_W{1'b0}}};
            s_d.rptr      = {cfg_data_i, {OFS_W{1'b0}}};
            s_d.fill      = '0;
        end
        if (flush_i) begin
            s_d.wptr = {s_d.first_reg, {OFS_W{1'b0}}};
            s_d.rptr = {s_d.first_reg, {OFS_W{1'b0}}};
            s_d.fill = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign wptr_o = s_q.wptr;
    assign rptr_o = s_q.rptr;
    assign ovf_o  = s_q.ovf;

    // R5
    ovf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.ovf && !ovf_clr_i) |=> s_q.ovf);

    // R4
    drop_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit_i && full_o) |=> s_q.ovf);

    // R6
    empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_hit_i && empty_o && !first_we_i && !flush_i) |=> $stable(s_q.rptr));

    // R3
    wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit_i && !full_o && s_q.wptr == top && !first_we_i && !flush_i)
        |=> (s_q.wptr[OFS_W-1:0] == '0 && s_q.wptr[ADDR_W-1:OFS_W] == s_q.first_reg));

    // R8
    rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        first_we_i |=> (s_q.fill == '0 && s_q.wptr == s_q.rptr && s_q.wptr[OFS_W-1:0] == '0));

    // R10
    flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> (s_q.fill == '0 && s_q.wptr == s_q.rptr));
endmodule

// File: rtl/qpm_core.sv
module qpm_core
    import qpm_pkg::*;
#(
    parameter int unsigned NUM_Q   = 8,
    parameter int unsigned NUM_WMQ = 4,
    localparam int unsigned QID_W  = (NUM_Q > 1) ? $clog2(NUM_Q) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [QID_W-1:0]  cfg_qid,
    input  logic [1:0]        cfg_field,
    input  logic [REG_W-1:0]  cfg_data,
    input  logic              flush_all,
    input  logic [NUM_Q-1:0]  ovf_clr,
    input  logic              wr_req,
    input  logic [QID_W-1:0]  wr_qid,
    output logic [ADDR_W-1:0] wr_addr,
    output logic              wr_accept,
    input  logic              rd_req,
    input  logic [QID_W-1:0]  rd_qid,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              rd_valid,
    output logic [NUM_Q-1:0]  watermark,
    output logic [NUM_Q-1:0]  ovf_status
);
    logic [NUM_Q-1:0]  first_we, last_we, thr_we, wr_hit, rd_hit, full, empty;
    logic [ADDR_W-1:0] wptr [NUM_Q];
    logic [ADDR_W-1:0] rptr [NUM_Q];
    cfg_field_e        fld;

    assign fld = cfg_field_e'(cfg_field);

    always_comb begin
        for (int i = 0; i < NUM_Q; i++) begin
            first_we[i] = cfg_we && (cfg_qid == QID_W'(i)) && (fld == FLD_FIRST);
            last_we[i]  = cfg_we && (cfg_qid == QID_W'(i)) && (fld == FLD_LAST);
            thr_we[i]   = cfg_we && (cfg_qid == QID_W'(i)) && (fld == FLD_THRESH);
            wr_hit[i]   = wr_req && (wr_qid == QID_W'(i));
            rd_hit[i]   = rd_req && (rd_qid == QID_W'(i));
        end
    end

    for (genvar g = 0; g < NUM_Q; g++) begin : g_slot
        qpm_queue_slot #(.HAS_WM(g < NUM_WMQ)) u_slot (
            .clk        (clk),
            .rst_n      (rst_n),
            .first_we_i (first_we[g]),
            .last_we_i  (last_we[g]),
            .thr_we_i   (thr_we[g]),
            .cfg_data_i (cfg_data),
            .flush_i    (flush_all),
            .wr_hit_i   (wr_hit[g]),
            .rd_hit_i   (rd_hit[g]),
            .ovf_clr_i  (ovf_clr[g]),
            .wptr_o     (wptr[g]),
            .rptr_o     (rptr[g]),
            .full_o     (full[g]),
            .empty_o    (empty[g]),
            .wmark_o    (watermark[g]),
            .ovf_o      (ovf_status[g])
        );
    end

    always_comb begin
        wr_addr   = '0;
        rd_addr   = '0;
        wr_accept = 1'b0;
        rd_valid  = 1'b0;
        for (int i = 0; i < NUM_Q; i++) begin
            if (wr_qid == QID_W'(i)) begin
                wr_addr   = wptr[i];
                wr_accept = wr_req && !full[i];
            end
            if (rd_qid == QID_W'(i)) begin
                rd_addr  = rptr[i];
                rd_valid = rd_req && !empty[i];
            end
        end
    end

    // R11
    wm_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (watermark >> NUM_WMQ) == '0);

    // R4
    accept_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_accept |-> (wr_req && $onehot0(wr_hit)));
endmodule

// File: tb/qpm_core_bench.sv
`timescale 1ns/1ps
module qpm_core_bench;
    localparam int NQ  = 8;
    localparam int NWM = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_qid = '0;
    logic [1:0]  cfg_field = '0;
    logic [9:0]  cfg_data = '0;
    logic        flush_all = 1'b0;
    logic [7:0]  ovf_clr = '0;
    logic        wr_req = 1'b0;
    logic [2:0]  wr_qid = '0;
    logic [23:0] wr_addr;
    logic        wr_accept;
    logic        rd_req = 1'b0;
    logic [2:0]  rd_qid = '0;
    logic [23:0] rd_addr;
    logic        rd_valid;
    logic [7:0]  watermark;
    logic [7:0]  ovf_status;

    always #2.5 clk = ~clk;

    qpm_core u_qpm_core (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_qid(cfg_qid),
        .cfg_field(cfg_field), .cfg_data(cfg_data), .flush_all(flush_all),
        .ovf_clr(ovf_clr), .wr_req(wr_req), .wr_qid(wr_qid), .wr_addr(wr_addr),
        .wr_accept(wr_accept), .rd_req(rd_req), .rd_qid(rd_qid), .rd_addr(rd_addr),
        .rd_valid(rd_valid), .watermark(watermark), .ovf_status(ovf_status)
    );

    int    checks = 0;
    int    errors = 0;
    string phase = "R1";

    int     m_first [NQ];
    int     m_last  [NQ];
    int     m_thr   [NQ];
    longint m_wp    [NQ];
    longint m_rp    [NQ];
    longint m_fill  [NQ];
    bit     m_ovf   [NQ];

    function automatic longint mbase(int q); return longint'(m_first[q]) << 14; endfunction
    function automatic longint mtop(int q);  return (longint'(m_last[q]) << 14) + 16383; endfunction
    function automatic longint mcap(int q);
        return (m_last[q] >= m_first[q]) ? (longint'(m_last[q] - m_first[q] + 1) << 14) : 0;
    endfunction
    function automatic longint mstep(int q, longint p);
        return (p == mtop(q)) ? mbase(q) : ((p + 1) % (longint'(1) << 24));
    endfunction

    task automatic chk(string tag, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", phase, tag, act, exp);
        end
    endtask

    task automatic compare_all();
        int wq = int'(wr_qid);
        int rq = int'(rd_qid);
        chk("R2 wr_addr", longint'(wr_addr), m_wp[wq]);
        chk("R4 wr_accept", longint'(wr_accept), longint'(wr_req && (m_fill[wq] < mcap(wq))));
        chk("R2 rd_addr", longint'(rd_addr), m_rp[rq]);
        chk("R6 rd_valid", longint'(rd_valid), longint'(rd_req && (m_fill[rq] > 0)));
        for (int q = 0; q < NQ; q++) begin
            chk("R11 watermark", longint'(watermark[q]),
                longint'(q < NWM && m_thr[q] != 0 && m_fill[q] >= (longint'(m_thr[q]) << 14)));
            chk("R5 ovf_status", longint'(ovf_status[q]), longint'(m_ovf[q]));
        end
    endtask

    task automatic model_edge();
        int  wq = int'(wr_qid);
        int  rq = int'(rd_qid);
        bit  wgo = wr_req && (m_fill[wq] < mcap(wq));
        bit  rgo = rd_req && (m_fill[rq] > 0);
        int  cq = int'(cfg_qid);
        if (wgo) begin m_wp[wq] = mstep(wq, m_wp[wq]); m_fill[wq]++; end
        if (rgo) begin m_rp[rq] = mstep(rq, m_rp[rq]); m_fill[rq]--; end
        for (int q = 0; q < NQ; q++) if (ovf_clr[q]) m_ovf[q] = 1'b0;
        if (wr_req && !wgo) m_ovf[wq] = 1'b1;
        if (cfg_we) begin
            case (cfg_field)
                2'b00: begin
                    m_first[cq] = int'(cfg_data);
                    m_wp[cq] = mbase(cq); m_rp[cq] = mbase(cq); m_fill[cq] = 0;
                end
                2'b01: m_last[cq] = int'(cfg_data);
                2'b10: if (cq < NWM) m_thr[cq] = int'(cfg_data);
                default: ;
            endcase
        end
        if (flush_all) begin
            for (int q = 0; q < NQ; q++) begin
                m_wp[q] = mbase(q); m_rp[q] = mbase(q); m_fill[q] = 0;
            end
        end
    endtask

    task automatic cycle();
        #1;
        compare_all();
        @(posedge clk);
        model_edge();
        @(negedge clk);
    endtask

    task automatic idle();
        cfg_we = 1'b0; flush_all = 1'b0; ovf_clr = '0; wr_req = 1'b0; rd_req = 1'b0;
    endtask

    task automatic cfg(int q, int fld, int val);
        idle();
        cfg_we = 1'b1; cfg_qid = 3'(q); cfg_field = 2'(fld); cfg_data = 10'(val);
        cycle();
        idle();
    endtask

    task automatic acc(bit w, int wq, bit r, int rq);
        idle();
        wr_req = w; wr_qid = 3'(wq); rd_req = r; rd_qid = 3'(rq);
        cycle();
        idle();
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int q = 0; q < NQ; q++) begin
            m_first[q] = 0; m_last[q] = 0; m_thr[q] = 0;
            m_wp[q] = 0; m_rp[q] = 0; m_fill[q] = 0; m_ovf[q] = 1'b0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state on every queue
        phase = "R1";
        for (int q = 0; q < NQ; q++) acc(1'b0, q, 1'b0, q);

        // R9: region and threshold setup; threshold on a no-watermark queue ignored
        phase = "R9";
        cfg(1, 1, 3); cfg(1, 0, 2);
        cfg(2, 1, 4); cfg(2, 0, 5);
        cfg(0, 2, 1);
        cfg(5, 2, 1);
        cfg(6, 3, 7);
        // R12: q3 overlaps q0 (both region 0)
        cfg(3, 0, 0); cfg(0, 0, 0);

        // R4: inverted region has zero capacity
        phase = "R4";
        acc(1'b1, 2, 1'b1, 2);
        acc(1'b0, 2, 1'b0, 2);

        // R12: overlapping queue stays independent while q0 fills
        phase = "R12";
        acc(1'b1, 3, 1'b0, 3);

        // R3 R4 R11: fill q0 to exactly one region, then push past it
        phase = "R4";
        for (int i = 0; i < 16384 + 2; i++) acc(1'b1, 0, 1'b0, 3);

        // R5: clear and simultaneous set beats clear
        phase = "R5";
        ovf_clr = 8'h01; wr_req = 1'b1; wr_qid = 3'd0; cycle(); idle();
        ovf_clr = 8'h01; cycle(); idle();
        ovf_clr = 8'h04; cycle(); idle();

        // R3 R6: drain q0, one refused read, then wrap check
        phase = "R3";
        for (int i = 0; i < 16384 + 1; i++) acc(1'b0, 0, 1'b1, 0);
        acc(1'b1, 0, 1'b0, 0);
        acc(1'b1, 0, 1'b1, 0);

        // R7: random traffic with frequent same-queue collisions
        phase = "R7";
        for (int i = 0; i < 4000; i++) begin
            idle();
            wr_req = 1'($urandom_range(0, 3) != 0);
            rd_req = 1'($urandom_range(0, 2) != 0);
            wr_qid = 3'($urandom_range(0, 1) == 0 ? 1 : $urandom_range(0, 7));
            rd_qid = ($urandom_range(0, 1) == 0) ? wr_qid : 3'($urandom_range(0, 7));
            cycle();
        end
        idle();

        // R9: last-region change with traffic keeps pointers
        phase = "R9";
        cfg_we = 1'b1; cfg_qid = 3'd1; cfg_field = 2'b01; cfg_data = 10'd4;
        wr_req = 1'b1; wr_qid = 3'd1; cycle(); idle();

        // R8: re-arm overrides same-cycle traffic on that queue
        phase = "R8";
        cfg_we = 1'b1; cfg_qid = 3'd1; cfg_field = 2'b00; cfg_data = 10'd3;
        wr_req = 1'b1; wr_qid = 3'd1; rd_req = 1'b1; rd_qid = 3'd1; cycle(); idle();
        acc(1'b0, 1, 1'b1, 1);
        acc(1'b1, 1, 1'b0, 1);

        // R10: flush with traffic, then observe all queues
        phase = "R10";
        acc(1'b1, 4, 1'b0, 4);
        flush_all = 1'b1; wr_req = 1'b1; wr_qid = 3'd4; cycle(); idle();
        for (int q = 0; q < NQ; q++) acc(1'b0, q, 1'b1, q);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule